// File: doc/BRIEF.md
# Programmable LED Output Controller

This block drives four LED pins of a network PHY. Each pin has a 2-bit mode field of its own. The four modes are: show a status event chosen from a table, lit under software control, dark under software control, or blink from an internal timer. In the event mode a shared 2-bit function select picks one of four tables that map the PHY status onto the four pins. The status inputs are link, activity, speed, duplex and collision.

Pins 0 and 1 can sink and source current. In the event mode they always drive, so one pin can light either an LED tied to the supply (pin low) or an LED tied to ground (pin high). This lets a single pin show speed or duplex. Pins 2 and 3 act as open-drain outputs: when unlit they release the pad (output-enable low) instead of driving it high.

Activity and collision pulses can last a single cycle. They are stretched so that a one-frame event stays visible. The blink and stretch lengths are parameters given in clock cycles. The defaults match 100 ms and 50 ms at 25 MHz.

Top module: `lamp_drive_ctrl`

## Requirements
- R1: Pin k takes its mode from pinMode[2k+1:2k], with 0 = event, 1 = lit, 2 = dark, 3 = blink. Both outputs are registered and follow the inputs sampled at the previous rising clock edge.
- R2: In mode 1 the pin drives low: ledOe=1 and ledDrive=0.
- R3: In mode 2 the pin is released: ledOe=0. A released pin always shows ledDrive=1, whatever mode it is in.
- R4: In mode 3 the pin is lit (ledOe=1, ledDrive=0) in the first output cycle after it enters blink mode. It then stays lit for BLINK_CYCLES output cycles and released for BLINK_CYCLES cycles, and repeats. Leaving blink mode and entering it again restarts the pattern from the lit phase.
- R5: In event mode, the event table gives "lit" for each pin. funcSel 0: pin0 speed100, pin1 fullDuplex, pin2 linkUp, pin3 stretched activity. funcSel 1: pin3 becomes stretched collision, the rest as in 0. funcSel 2: pin0 speed100, pin1 fullDuplex, pin2 stretched activity, pin3 stretched collision. funcSel 3: pin0 linkUp, pin1 stretched activity, pin2 stretched collision, pin3 linkUp AND speed100. On pins 2 and 3, lit means ledOe=1 and ledDrive=0; unlit means released.
- R6: In event mode pins 0 and 1 always drive (ledOe=1). They drive 0 when their table entry is true and 1 when it is false. So pin0 drives low at 100 Mbps and high at 10 Mbps, and pin1 drives low for full duplex and high for half duplex.
- R7: A stretched event is true in the cycle its input is high and for STRETCH_CYCLES cycles after the last such cycle. A new pulse arriving while the stretch is running restarts the full count.
- R8: While rstN is low, every pin is released (ledOe=0, ledDrive=1), and all blink and stretch state is cleared. A pulse seen before reset therefore leaves no stretched event after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinMode | input | 8 | Two mode bits per pin |
| funcSel | input | 2 | Event table select |
| linkUp | input | 1 | Link established |
| activity | input | 1 | Frame activity pulse |
| speed100 | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| fullDuplex | input | 1 | 1 = full duplex, 0 = half duplex |
| collision | input | 1 | Collision pulse |
| ledDrive | output | 4 | Pad drive value per pin |
| ledOe | output | 4 | Pad output-enable per pin |

## Verification
Two functions can fall in the same cycle:
- A stretch counter's last lit cycle can coincide with a fresh activity pulse. The bench aligns a second pulse exactly on that last cycle, and the pin must stay lit without a gap for a full new stretch.
- A pin can leave blink mode and enter it again while its phase counter is about to toggle. The bench does this in the middle of a dark phase, and the pin must come back lit and count a whole lit phase.

A cycle-accurate bench model judges both events, and the same model judges a long seeded random run of mode, select and status changes.

// File: rtl/lamp_pkg.sv
package lamp_pkg;
  localparam int NUM_LAMPS = 4;

  typedef enum logic [1:0] {
    MODE_EVENT = 2'd0,
    MODE_ON    = 2'd1,
    MODE_OFF   = 2'd2,
    MODE_BLINK = 2'd3
  } lampMode_e;

  // strobes from the timing control to the output datapath
  typedef struct packed {
    logic                 actLit;
    logic                 colLit;
    logic [NUM_LAMPS-1:0] blinkLit;
  } lampStrobe_t;
endpackage

// File: rtl/lamp_timing.sv
module lamp_timing
  import lamp_pkg::*;
#(
  parameter int BLINK_CYCLES   = 2500000,
  parameter int STRETCH_CYCLES = 1250000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [2*NUM_LAMPS-1:0] pinMode,
  input  logic                   activity,
  input  logic                   collision,
  output lampStrobe_t            strobes
);
  localparam int BW = $clog2(BLINK_CYCLES + 1);
  localparam int SW = $clog2(STRETCH_CYCLES + 1);
  localparam logic [BW-1:0] PHASE_LAST = BW'(BLINK_CYCLES - 1);
  localparam logic [SW-1:0] STRETCH_LOAD = SW'(STRETCH_CYCLES);

  // event stretchers: index 0 = activity, 1 = collision
  logic [1:0] evIn;
  logic [1:0] evLit;
  assign evIn = {collision, activity};

  for (genvar e = 0; e < 2; e++) begin : g_stretch
    logic [SW-1:0] holdCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               holdCnt <= '0;
      else if (evIn[e])        holdCnt <= STRETCH_LOAD;
      else if (holdCnt != '0)  holdCnt <= holdCnt - 1'b1;
    end
    assign evLit[e] = evIn[e] || (holdCnt != '0);
  end

  assign strobes.actLit = evLit[0];
  assign strobes.colLit = evLit[1];

  // one blink timer per pin so that each restarts on its own entry
  for (genvar k = 0; k < NUM_LAMPS; k++) begin : g_blink
    logic          inBlinkQ;
    logic          phaseQ;
    logic [BW-1:0] phaseCnt;
    logic          isBlink;
    logic          entering;

    assign isBlink  = lampMode_e'(pinMode[2*k +: 2]) == MODE_BLINK;
    assign entering = isBlink && !inBlinkQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inBlinkQ <= 1'b0;
        phaseQ   <= 1'b1;
        phaseCnt <= '0;
      end else begin
        inBlinkQ <= isBlink;
        if (entering) begin
          phaseQ   <= 1'b1;
          phaseCnt <= BW'(1);
        end else if (isBlink) begin
          if (phaseCnt == PHASE_LAST) begin
            phaseCnt <= '0;
            phaseQ   <= !phaseQ;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
      end
    end

    assign strobes.blinkLit[k] = entering || phaseQ;
  end
endmodule

// File: rtl/lamp_mux.sv
module lamp_mux
  import lamp_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [2*NUM_LAMPS-1:0] pinMode,
  input  logic [1:0]             funcSel,
  input  logic                   linkUp,
  input  logic                   speed100,
  input  logic                   fullDuplex,
  input  lampStrobe_t            strobes,
  output logic [NUM_LAMPS-1:0]   ledDrive,
  output logic [NUM_LAMPS-1:0]   ledOe
);
  localparam int PUSH_PULL_PINS = 2;

  logic [NUM_LAMPS-1:0] eventLit;

  always_comb begin
    unique case (funcSel)
      2'd0:    eventLit = {strobes.actLit, linkUp, fullDuplex, speed100};
      2'd1:    eventLit = {strobes.colLit, linkUp, fullDuplex, speed100};
      2'd2:    eventLit = {strobes.colLit, strobes.actLit, fullDuplex, speed100};
      default: eventLit = {linkUp && speed100, strobes.colLit, strobes.actLit, linkUp};
    endcase
  end

  for (genvar k = 0; k < NUM_LAMPS; k++) begin : g_pin
    logic litNext;
    logic oeNext;

    always_comb begin
      unique case (lampMode_e'(pinMode[2*k +: 2]))
        MODE_EVENT: begin
          litNext = eventLit[k];
          oeNext  = (k < PUSH_PULL_PINS) ? 1'b1 : eventLit[k];
        end
        MODE_ON: begin
          litNext = 1'b1;
          oeNext  = 1'b1;
        end
        MODE_OFF: begin
          litNext = 1'b0;
          oeNext  = 1'b0;
        end
        default: begin
          litNext = strobes.blinkLit[k];
          oeNext  = strobes.blinkLit[k];
        end
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ledOe[k]    <= 1'b0;
        ledDrive[k] <= 1'b1;
      end else begin
        ledOe[k]    <= oeNext;
        ledDrive[k] <= !(litNext && oeNext);
      end
    end
  end
endmodule

// File: rtl/lamp_drive_ctrl.sv
module lamp_drive_ctrl
  import lamp_pkg::*;
#(
  parameter int BLINK_CYCLES   = 2500000,
  parameter int STRETCH_CYCLES = 1250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] pinMode,
  input  logic [1:0] funcSel,
  input  logic       linkUp,
  input  logic       activity,
  input  logic       speed100,
  input  logic       fullDuplex,
  input  logic       collision,
  output logic [3:0] ledDrive,
  output logic [3:0] ledOe
);
  lampStrobe_t strobes;

  lamp_timing #(
    .BLINK_CYCLES  (BLINK_CYCLES),
    .STRETCH_CYCLES(STRETCH_CYCLES)
  ) u_timing (
    .clk      (clk),
    .rstN     (rstN),
    .pinMode  (pinMode),
    .activity (activity),
    .collision(collision),
    .strobes  (strobes)
  );

  lamp_mux u_mux (
    .clk       (clk),
    .rstN      (rstN),
    .pinMode   (pinMode),
    .funcSel   (funcSel),
    .linkUp    (linkUp),
    .speed100  (speed100),
    .fullDuplex(fullDuplex),
    .strobes   (strobes),
    .ledDrive  (ledDrive),
    .ledOe     (ledOe)
  );
endmodule

// File: rtl/lamp_drive_chk.sv
module lamp_drive_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] pinMode,
  input logic [1:0] funcSel,
  input logic       activity,
  input logic [3:0] ledDrive,
  input logic [3:0] ledOe
);
  for (genvar k = 0; k < 4; k++) begin : g_pin_chk
    p_forced_on_r2: assert property (@(posedge clk) disable iff (!rstN)
      (pinMode[2*k +: 2] == 2'd1) |=> (ledOe[k] && !ledDrive[k]));

    p_forced_off_r3: assert property (@(posedge clk) disable iff (!rstN)
      (pinMode[2*k +: 2] == 2'd2) |=> !ledOe[k]);

    p_released_high_r3: assert property (@(posedge clk) disable iff (!rstN)
      !ledOe[k] |-> ledDrive[k]);

    p_blink_entry_r4: assert property (@(posedge clk) disable iff (!rstN)
      ((pinMode[2*k +: 2] == 2'd3) && ($past(pinMode[2*k +: 2]) != 2'd3))
      |=> (ledOe[k] && !ledDrive[k]));
  end

  p_push_pull_pin0_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pinMode[1:0] == 2'd0) |=> ledOe[0]);

  p_push_pull_pin1_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pinMode[3:2] == 2'd0) |=> ledOe[1]);

  p_stretch_visible_r7: assert property (@(posedge clk) disable iff (!rstN)
    (funcSel == 2'd0 && pinMode[7:6] == 2'd0 && activity) |=> (ledOe[3] && !ledDrive[3]));

  p_reset_release_r8: assert property (@(posedge clk)
    !rstN |=> (ledOe == 4'b0000 && ledDrive == 4'b1111));
endmodule

bind lamp_drive_ctrl lamp_drive_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .pinMode (pinMode),
  .funcSel (funcSel),
  .activity(activity),
  .ledDrive(ledDrive),
  .ledOe   (ledOe)
);

// File: tb/lamp_drive_ctrl_tb.sv
module lamp_drive_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BLINK      = 8;
  localparam int STRETCH    = 5;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] pinMode;
  logic [1:0] funcSel;
  logic       linkUp, activity, speed100, fullDuplex, collision;
  logic [3:0] ledDrive, ledOe;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // reference model state
  int mCnt[4];
  bit mPhase[4];
  bit mIn[4];
  int mAct, mCol;
  bit expOe[4];
  bit expDrv[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  lamp_drive_ctrl #(.BLINK_CYCLES(BLINK), .STRETCH_CYCLES(STRETCH)) u_dut (
    .clk(clk), .rstN(rstN), .pinMode(pinMode), .funcSel(funcSel),
    .linkUp(linkUp), .activity(activity), .speed100(speed100),
    .fullDuplex(fullDuplex), .collision(collision),
    .ledDrive(ledDrive), .ledOe(ledOe));

  function automatic bit eventLit(int k, bit act, bit col);
    case (funcSel)
      2'd0: return (k == 0) ? speed100 : (k == 1) ? fullDuplex : (k == 2) ? linkUp : act;
      2'd1: return (k == 0) ? speed100 : (k == 1) ? fullDuplex : (k == 2) ? linkUp : col;
      2'd2: return (k == 0) ? speed100 : (k == 1) ? fullDuplex : (k == 2) ? act : col;
      default: return (k == 0) ? linkUp : (k == 1) ? act : (k == 2) ? col : (linkUp && speed100);
    endcase
  endfunction

  function automatic string tagFor(int k);
    case (pinMode[2*k +: 2])
      2'd1: return "R2";
      2'd2: return "R3";
      2'd3: return "R4";
      default: return (k < 2) ? "R6" : "R5";
    endcase
  endfunction

  task automatic modelReset();
    for (int k = 0; k < 4; k++) begin
      mCnt[k] = 0; mPhase[k] = 1'b1; mIn[k] = 1'b0;
      expOe[k] = 1'b0; expDrv[k] = 1'b1;
    end
    mAct = 0; mCol = 0;
  endtask

  task automatic modelStep();
    bit act, col, lit, oe;
    act = activity || (mAct != 0);
    col = collision || (mCol != 0);
    for (int k = 0; k < 4; k++) begin
      bit bl;
      bl = 1'b0;
      if (pinMode[2*k +: 2] == 2'd3) begin
        if (!mIn[k]) begin
          bl = 1'b1; mPhase[k] = 1'b1; mCnt[k] = 1;
        end else begin
          bl = mPhase[k];
          if (mCnt[k] == BLINK - 1) begin mCnt[k] = 0; mPhase[k] = !mPhase[k]; end
          else mCnt[k] = mCnt[k] + 1;
        end
      end
      mIn[k] = (pinMode[2*k +: 2] == 2'd3);
      case (pinMode[2*k +: 2])
        2'd0: begin lit = eventLit(k, act, col); oe = (k < 2) ? 1'b1 : lit; end
        2'd1: begin lit = 1'b1; oe = 1'b1; end
        2'd2: begin lit = 1'b0; oe = 1'b0; end
        default: begin lit = bl; oe = bl; end
      endcase
      expOe[k]  = oe;
      expDrv[k] = !(lit && oe);
    end
    mAct = activity ? STRETCH : ((mAct != 0) ? mAct - 1 : 0);
    mCol = collision ? STRETCH : ((mCol != 0) ? mCol - 1 : 0);
  endtask

  task automatic checkPins(string tag);
    for (int k = 0; k < 4; k++) begin
      string t;
      t = (tag != "") ? tag : tagFor(k);
      vectors++;
      if (ledOe[k] !== expOe[k] || ledDrive[k] !== expDrv[k]) begin
        fails++;
        $display("FAIL %s pin %0d: oe,drive = %b,%b expected %b,%b",
                 t, k, ledOe[k], ledDrive[k], expOe[k], expDrv[k]);
      end
    end
  endtask

  // inputs are set at the falling edge; the check follows the next rising edge
  task automatic stepCheck(string tag);
    modelStep();
    @(posedge clk);
    @(negedge clk);
    checkPins(tag);
  endtask

  task automatic pulseAct();
    activity = 1'b1;
    stepCheck("R7");
    activity = 1'b0;
  endtask

  initial begin
    rstN = 1'b0;
    pinMode = 8'h00; funcSel = 2'd0;
    linkUp = 0; activity = 0; speed100 = 0; fullDuplex = 0; collision = 0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkPins("R8");
    rstN = 1'b1;

    // R1: one pin in each mode at once
    linkUp = 1; speed100 = 1; fullDuplex = 0;
    pinMode = {2'd3, 2'd2, 2'd1, 2'd0};
    stepCheck("R1");
    stepCheck("R1");

    // R2 / R3: all pins lit, then all dark
    pinMode = 8'h55;
    stepCheck("R2");
    pinMode = 8'hAA;
    stepCheck("R3");

    // R6: push-pull pins follow speed and duplex both ways
    pinMode = 8'h00;
    speed100 = 1; fullDuplex = 1; stepCheck("R6");
    speed100 = 0; fullDuplex = 0; stepCheck("R6");

    // R4: blink on pin2, then leave in the middle of a dark phase and re-enter
    pinMode = {2'd2, 2'd3, 2'd2, 2'd2};
    for (int i = 0; i < BLINK + 3; i++) stepCheck("R4");
    pinMode = 8'hAA;
    stepCheck("R4");
    pinMode = {2'd2, 2'd3, 2'd2, 2'd2};
    for (int i = 0; i < 3 * BLINK; i++) stepCheck("R4");

    // R7: single pulse, then a retrigger on the last stretched cycle
    pinMode = 8'h00; funcSel = 2'd0;
    stepCheck("R7");
    pulseAct();
    for (int i = 0; i < STRETCH + 2; i++) stepCheck("R7");
    pulseAct();
    for (int i = 0; i < STRETCH - 1; i++) stepCheck("R7");
    pulseAct();
    for (int i = 0; i < STRETCH + 2; i++) stepCheck("R7");

    // R5: each table with collision and activity
    for (int f = 0; f < 4; f++) begin
      funcSel = 2'(f);
      collision = 1'b1; stepCheck("R5");
      collision = 1'b0; stepCheck("R5");
      pulseAct();
      stepCheck("R5");
    end

    // R8: reset in the middle of a stretch clears it
    funcSel = 2'd0; pinMode = 8'h00;
    activity = 1'b1; modelStep(); @(posedge clk); @(negedge clk);
    activity = 1'b0;
    rstN = 1'b0;
    @(posedge clk); @(negedge clk);
    modelReset();
    checkPins("R8");
    rstN = 1'b1;
    stepCheck("R8");

    // seeded random mix
    void'($urandom(32'd4242));
    for (int i = 0; i < 3000; i++) begin
      for (int k = 0; k < 4; k++)
        if ($urandom_range(15) == 0) pinMode[2*k +: 2] = 2'($urandom_range(3));
      if ($urandom_range(29) == 0) funcSel = 2'($urandom_range(3));
      if ($urandom_range(7) == 0) linkUp = !linkUp;
      if ($urandom_range(7) == 0) speed100 = !speed100;
      if ($urandom_range(7) == 0) fullDuplex = !fullDuplex;
      activity  = ($urandom_range(11) == 0);
      collision = ($urandom_range(19) == 0);
      stepCheck("");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule